// File: doc/BRIEF.md
# Symmetric Distributed-Arithmetic Lowpass FIR Filter

This block is a 53-tap lowpass FIR filter whose coefficients are fixed when the design is built. The caller presents a signed 16-bit sample on `din` and pulses `nd` for one cycle. The filter pushes the sample into its history and computes the weighted sum of the newest 53 samples. It then pulses `rdy` for one cycle, with the full-precision result on `dout`.

The coefficient set is mirror-symmetric, so the filter first adds each pair of samples that share a weight. The 26 sums are each 17 bits wide, and the centre sample is kept alone, which gives 27 operands. The filter uses no multipliers. Each clock it takes one bit of every operand, starting from the LSB, and these bits address small lookup tables. Each table holds the precomputed partial sums for four coefficients. A shift-accumulator combines the table outputs and subtracts them on the sign-bit cycle.

The filter handles one sample at a time. A request that arrives while a computation is still running is dropped.

Top module: `fir_da_sym`

## Requirements
- R1: While reset is held, `rdy` is 0 and `dout` is 0, and the sample history is all zeros.
- R2: Each output equals the sum over k = 0..52 of c[k]·x[n-k], where x[n] is the newest accepted sample and x[n-k] for k > 0 are the earlier accepted samples (zero before any were accepted). c[k] = c[52-k], and c[0..26] = -6, -11, -15, -14, -5, 12, 33, 50, 53, 33, -12, -74, -134, -165, -140, -36, 150, 399, 728, 1130, 1580, 2050, 2510, 2930, 3280, 3520, 3605.
- R3: A request is accepted on the rising edge where `nd` is 1 and the filter is idle. `rdy` is 1 for exactly one cycle, and its rising edge comes 18 clock edges after the accepting edge.
- R4: An `nd` pulse that is sampled between an accepting edge and the edge that raises `rdy` (that edge included) is ignored. It produces no `rdy` and does not enter the sample history. An `nd` sampled on the edge right after the one that raised `rdy` is accepted.
- R5: `dout` is a 37-bit two's-complement value with no rounding or saturation. It is exact for full-scale inputs of both signs, including -32768 in both halves of a mirrored pair.
- R6: `dout` changes only on the edge that raises `rdy`, and it holds its value at all other times.
- R7: A constant input of value v, applied for 53 or more samples, gives v times the sum of all 53 coefficients. A single unit sample followed by zeros gives the coefficients in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| nd | input | 1 | One-cycle strobe: take `din` as the next sample |
| din | input | 16 | Signed input sample |
| rdy | output | 1 | One-cycle strobe: `dout` holds a new result |
| dout | output | 37 | Signed full-precision filter output |

## Verification
A new request can arrive in the same cycle as the last accumulation step, which is the step that produces `rdy` and the result. The bench provokes this by pulsing `nd` on the clock edge where the result is written, and on an edge in the middle of the computation. It then sends a real sample on the very next edge. The dropped request must give no extra `rdy` and leave the history untouched. The bench judges this at the ports: every later output must match a reference convolution that never saw the dropped sample. The back-to-back sample must still appear exactly 18 edges later.

// File: rtl/fir_da_pkg.sv
package fir_da_pkg;

  localparam int NTAPS  = 53;
  localparam int COEF_W = 14;
  localparam int HALF_N = (NTAPS + 1) / 2;

  // unique half of the mirror-symmetric response, outer tap first
  localparam logic signed [COEF_W-1:0] COEF_HALF [HALF_N] = '{
    -14'sd6,   -14'sd11,  -14'sd15,  -14'sd14,  -14'sd5,   14'sd12,
     14'sd33,   14'sd50,   14'sd53,   14'sd33,  -14'sd12,  -14'sd74,
    -14'sd134, -14'sd165, -14'sd140, -14'sd36,   14'sd150,  14'sd399,
     14'sd728,  14'sd1130, 14'sd1580, 14'sd2050, 14'sd2510, 14'sd2930,
     14'sd3280, 14'sd3520, 14'sd3605
  };

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_ACC} fir_phase_e;

  // weight of distributed-arithmetic operand j (zero beyond the real set)
  function automatic int coef_at(input int j);
    if (j < HALF_N) return int'(COEF_HALF[j]);
    return 0;
  endfunction

  // partial sum stored at address addr of lookup group grp
  function automatic int group_psum(input int grp, input int gw, input int addr);
    int s;
    s = 0;
    for (int i = 0; i < gw; i++)
      if (((addr >> i) & 1) != 0) s += coef_at(grp * gw + i);
    return s;
  endfunction

endpackage

// File: rtl/fir_delay_line.sv
module fir_delay_line #(
  parameter int DW = 16,
  parameter int N  = 53
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic [DW-1:0]        din,
  output logic [N-1:0][DW-1:0] taps
);

  // taps[0] holds the newest sample
  always_ff @(posedge clk) begin
    if (!rst_n)        taps <= '0;
    else if (shift_en) taps <= {taps[N-2:0], din};
  end

endmodule

// File: rtl/fir_preadd_bank.sv
module fir_preadd_bank #(
  parameter int DW  = 16,
  parameter int N   = 53,
  parameter int NIN = (N + 1) / 2,
  parameter int PW  = DW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 shift,
  input  logic [N-1:0][DW-1:0] taps,
  output logic [NIN-1:0]       bits
);

  localparam int NPAIR = N / 2;

  logic [NIN-1:0][PW-1:0] pre;
  logic [NIN-1:0][PW-1:0] shr;

  for (genvar j = 0; j < NPAIR; j++) begin : g_pair
    assign pre[j] = {taps[j][DW-1], taps[j]} + {taps[N-1-j][DW-1], taps[N-1-j]};
  end

  if (N % 2 == 1) begin : g_centre
    assign pre[NIN-1] = {taps[NPAIR][DW-1], taps[NPAIR]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) shr <= '0;
    else if (load) shr <= pre;
    else if (shift) begin
      for (int j = 0; j < NIN; j++) shr[j] <= {shr[j][PW-1], shr[j][PW-1:1]};
    end
  end

  for (genvar j = 0; j < NIN; j++) begin : g_bit
    assign bits[j] = shr[j][0];
  end

endmodule

// File: rtl/fir_da_lut.sv
module fir_da_lut
  import fir_da_pkg::*;
#(
  parameter int GRP_W   = 4,
  parameter int GRP_IDX = 0,
  parameter int LUT_W   = 17
) (
  input  logic [GRP_W-1:0]        addr,
  output logic signed [LUT_W-1:0] psum
);

  localparam int DEPTH = 2 ** GRP_W;

  logic signed [LUT_W-1:0] rom [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_entry
    assign rom[a] = LUT_W'(group_psum(GRP_IDX, GRP_W, a));
  end

  assign psum = rom[addr];

endmodule

// File: rtl/fir_da_sym.sv
module fir_da_sym
  import fir_da_pkg::*;
#(
  parameter int DIN_W = 16,
  parameter int GRP_W = 4
) (
  input  logic                                            clk,
  input  logic                                            rst_n,
  input  logic                                            nd,
  input  logic signed [DIN_W-1:0]                         din,
  output logic                                            rdy,
  output logic signed [DIN_W+COEF_W+$clog2(HALF_N)+1:0]   dout
);

  localparam int PRE_W   = DIN_W + 1;
  localparam int N_GRP   = (HALF_N + GRP_W - 1) / GRP_W;
  localparam int PAD_N   = N_GRP * GRP_W;
  localparam int LUT_W   = COEF_W + $clog2(GRP_W) + 1;
  localparam int SUM_W   = LUT_W + $clog2(N_GRP) + 1;
  localparam int OUT_W   = DIN_W + COEF_W + $clog2(HALF_N) + 2;
  localparam int CNT_W   = $clog2(PRE_W);
  localparam int LATENCY = PRE_W + 1;
  localparam int LAT_W   = $clog2(LATENCY + 2);

  fir_phase_e                   phase;
  logic [CNT_W-1:0]             bit_cnt;
  logic signed [OUT_W-1:0]      acc, acc_next, term;
  logic [NTAPS-1:0][DIN_W-1:0]  taps;
  logic [HALF_N-1:0]            bits;
  logic [PAD_N-1:0]             bits_pad;
  logic signed [LUT_W-1:0]      lut_out [N_GRP];
  logic signed [SUM_W-1:0]      slice_sum;

  // named internal events
  logic accept, load_ev, acc_ev, last_bit;
  assign accept   = nd && (phase == PH_IDLE);
  assign load_ev  = (phase == PH_LOAD);
  assign acc_ev   = (phase == PH_ACC);
  assign last_bit = acc_ev && (bit_cnt == CNT_W'(PRE_W - 1));

  fir_delay_line #(.DW(DIN_W), .N(NTAPS)) u_delay (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .din(din), .taps(taps)
  );

  fir_preadd_bank #(.DW(DIN_W), .N(NTAPS), .NIN(HALF_N), .PW(PRE_W)) u_preadd (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .shift(acc_ev), .taps(taps), .bits(bits)
  );

  assign bits_pad = PAD_N'(bits);

  for (genvar g = 0; g < N_GRP; g++) begin : g_lut
    fir_da_lut #(.GRP_W(GRP_W), .GRP_IDX(g), .LUT_W(LUT_W)) u_lut (
      .addr(bits_pad[g*GRP_W +: GRP_W]), .psum(lut_out[g])
    );
  end

  always_comb begin
    slice_sum = '0;
    for (int g = 0; g < N_GRP; g++) slice_sum = slice_sum + SUM_W'(lut_out[g]);
  end

  // bit weight 2^b; the operand sign bit carries negative weight
  assign term     = OUT_W'(slice_sum) <<< bit_cnt;
  assign acc_next = last_bit ? (acc - term) : (acc + term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      bit_cnt <= '0;
      acc     <= '0;
      dout    <= '0;
      rdy     <= 1'b0;
    end else begin
      rdy <= last_bit;
      unique case (phase)
        PH_IDLE: if (accept) phase <= PH_LOAD;
        PH_LOAD: begin
          phase   <= PH_ACC;
          bit_cnt <= '0;
          acc     <= '0;
        end
        PH_ACC: begin
          acc     <= acc_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (last_bit) begin
            dout  <= acc_next;
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // cycles since the accepting edge, for the latency property
  logic [LAT_W-1:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                 lat_cnt <= '0;
    else if (accept)            lat_cnt <= '0;
    else if (phase != PH_IDLE)  lat_cnt <= lat_cnt + 1'b1;
  end

  p_rdy_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |=> !rdy) else $error("rdy wider than one cycle");

  p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (lat_cnt == LAT_W'(LATENCY))) else $error("rdy latency wrong");

  p_bitcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ev |-> (bit_cnt < CNT_W'(PRE_W))) else $error("bit counter out of range");

  p_nd_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (nd && (phase != PH_IDLE)) |=> $stable(taps)) else $error("busy nd altered history");

  p_accept_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase == PH_LOAD)) else $error("accepted nd did not start load");

  p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy |-> $stable(dout)) else $error("dout moved without rdy");

endmodule

// File: tb/test_fir_da_sym.sv
`timescale 1ns/1ps
module test_fir_da_sym;

  localparam int DW  = 16;
  localparam int OW  = 37;
  localparam int NT  = 53;
  localparam int LAT = 18;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 nd = 1'b0;
  logic signed [DW-1:0] din = '0;
  logic                 rdy;
  logic signed [OW-1:0] dout;

  always #2 clk = ~clk;

  fir_da_sym #(.DIN_W(DW), .GRP_W(4)) i_fir_da_sym (
    .clk(clk), .rst_n(rst_n), .nd(nd), .din(din), .rdy(rdy), .dout(dout)
  );

  int     checks = 0;
  int     errors = 0;
  int     pend = 0;
  longint expv = 0;
  longint lastv = 0;
  string  tag = "R2";
  int     half_c [27] = '{-6, -11, -15, -14, -5, 12, 33, 50, 53, 33, -12, -74,
                          -134, -165, -140, -36, 150, 399, 728, 1130, 1580,
                          2050, 2510, 2930, 3280, 3520, 3605};
  int     coef [NT];
  longint hist [$];

  function automatic longint conv();
    longint s = 0;
    for (int k = 0; k < NT; k++) s += longint'(coef[k]) * hist[k];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one cycle of the reference model, compared at the falling edge
  task automatic tick();
    @(negedge clk);
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        check(rdy === 1'b1, "R3", longint'(rdy), 1);
        check(longint'(dout) == expv, tag, longint'(dout), expv);
        lastv = expv;
      end else begin
        check(rdy === 1'b0, "R3", longint'(rdy), 0);
        check(longint'(dout) == lastv, "R6", longint'(dout), lastv);
      end
    end else begin
      check(rdy === 1'b0, "R4", longint'(rdy), 0);
      check(longint'(dout) == lastv, "R6", longint'(dout), lastv);
    end
  endtask

  // send one sample; optionally pulse a stray nd when pend reaches 'at'
  task automatic send(input int v, input int at);
    bit done = 1'b0;
    nd  = 1'b1;
    din = DW'(v);
    void'(hist.pop_back());
    hist.push_front(longint'(v));
    expv = conv();
    pend = LAT + 1;
    tick();
    nd = 1'b0;
    while (pend > 0) begin
      if (pend == at && !done) begin
        nd   = 1'b1;
        din  = 16'sd12345;
        done = 1'b1;
      end
      tick();
      nd = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    for (int k = 0; k < NT; k++) coef[k] = half_c[(k < 27) ? k : (NT - 1 - k)];
    for (int k = 0; k < NT; k++) hist.push_back(0);

    // R1: reset state
    repeat (3) @(negedge clk);
    check(rdy === 1'b0, "R1", longint'(rdy), 0);
    check(longint'(dout) == 0, "R1", longint'(dout), 0);
    rst_n = 1'b1;
    tick();

    // R7 / R2: impulse gives the coefficients in order
    tag = "R7";
    send(1, 0);
    for (int i = 0; i < 54; i++) send(0, 0);

    // R7: step response settles to v * sum of coefficients
    for (int i = 0; i < 58; i++) send(1000, 0);

    // R5: full-scale inputs matched and opposed to coefficient signs
    tag = "R5";
    for (int m = 0; m < NT; m++) send((coef[m] >= 0) ? 32767 : -32768, 0);
    for (int m = 0; m < NT; m++) send((coef[m] >= 0) ? -32768 : 32767, 0);
    for (int m = 0; m < NT; m++) send(-32768, 0);

    // R2: random stream
    tag = "R2";
    for (int i = 0; i < 90; i++) begin
      logic [15:0] r = 16'($urandom);
      send(int'($signed(r)), 0);
    end

    // R4: stray nd mid-computation and on the result edge, then back-to-back
    tag = "R4";
    for (int i = 0; i < 6; i++) begin
      logic [15:0] r = 16'($urandom);
      send(int'($signed(r)), (i % 2 == 0) ? 1 : 10);
    end
    for (int i = 0; i < 4; i++) send(-7 * i + 3, 0);

    repeat (5) tick();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

endmodule